// File: doc/BRIEF.md
# Horizontal Two-Stage Bayer Binner

This block lowers the horizontal resolution of a Bayer-mosaic pixel stream. Pixels come in one row at a time. The two colors of a row interleave, so pixels at even offsets from the start of the line belong to one color and pixels at odd offsets to the other. Two cascaded stages each merge a run of same-color neighbours into one output per color. The horizontal factor is the product of the two stage factors, so it can be any of 1, 2, 3, 4, 6, 8, 9, 12 or 16.

Each stage offers three ways to merge a group:

- a plain rounded mean;
- a weighted mean that doubles the weight of one favoured member, chosen from the pixel's color and the row parity;
- subsampling, which keeps one member and drops the rest.

The output keeps the two colors alternating, and it marks the first pixel of each output line.

A stream source feeds one line after another, raising the start-of-line flag on the first pixel of each line. The stage factors, the mode bits and the row parity are captured on that first pixel and apply to the whole line.

Top module: `hbin_top`

## Requirements
- R1: Each stage factor input carries a code c from 0 to 3 that selects a stage factor F = c + 1. An input line of N pixels gives 2*floor(N/(2F)) stage-1 outputs. Stage 2 groups those outputs in the same way with its own factor, so the overall factor is the product of the two.
- R2: With both codes at 0, every complete pair of input pixels appears at the output unchanged and in the same order.
- R3: A stage takes 2F consecutive pixels as a group. The color-0 members sit at even offsets of the group and the color-1 members at odd offsets. It emits the color-0 result and then the color-1 result, on back-to-back cycles. No pixel is ever merged with a pixel of the other color.
- R4: With cfg_fav = 0 and cfg_sub = 0, a stage result is floor((S + floor(F/2)) / F), where S is the sum of the F same-color members. This is the mean rounded half up.
- R5: With cfg_fav = 1 and cfg_sub = 0, one member per color gets weight 2 and the others weight 1. If (color index XOR in_row_odd) is 0, the favoured member is the first of the group; otherwise it is the last. The result is floor((W + floor((F+1)/2)) / (F+1)), where W is the weighted sum. Both stages apply this rule with the row parity of the line.
- R6: With cfg_sub = 1, a stage result is the first same-color member of its group, and cfg_fav has no effect.
- R7: Pixels left after the last complete group of a line are dropped. A start-of-line pixel restarts grouping at offset 0. A line shorter than one group produces no output.
- R8: out_sol is high together with out_vld on the first output pixel of each line, and low at all other times.
- R9: cfg_fac1, cfg_fac2, cfg_sub, cfg_fav and in_row_odd are captured on the start-of-line pixel. Changes to them later in the line have no effect on that line's output.
- R10: While reset is held, and afterwards until a complete group has arrived, out_vld and out_sol stay low.
- R11: All factors and modes give exact results up to full scale: a line of all-maximum pixels gives maximum-valued outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a line; only meaningful with in_vld |
| in_row_odd | input | 1 | Parity of the Bayer row of the current line |
| in_pix | input | PIX_W | Input pixel value |
| cfg_fac1 | input | 2 | Stage-1 factor code (factor = code + 1) |
| cfg_fac2 | input | 2 | Stage-2 factor code (factor = code + 1) |
| cfg_sub | input | 1 | 1 = subsample, 0 = average |
| cfg_fav | input | 1 | 1 = favoured-member weighting, 0 = equal weighting |
| out_vld | output | 1 | Output pixel valid |
| out_sol | output | 1 | First output pixel of a line |
| out_pix | output | PIX_W | Output pixel value |

## Verification
The checker assumes that in_sol is raised only together with in_vld and that every line opens with such a pixel. Under that assumption it requires output pixels to leave in color pairs, with the line marker always on a color-0 pixel.

The stimulus raises in_sol only on the first valid pixel of each line and never on its own. It also scrambles the configuration inputs after that pixel, so that the capture rule of R9 is tested while the line is in flight.

// File: rtl/hbin_pkg.sv
package hbin_pkg;
   localparam int HB_FC_W = 2;

   typedef struct packed {
      logic [HB_FC_W-1:0] code;
      logic               sub;
      logic               fav;
      logic               odd;
   } hbin_scfg_t;
endpackage

// File: rtl/hbin_rdiv.sv
module hbin_rdiv #(
   parameter int NUM_W = 16,
   parameter int Q_W   = 12,
   parameter int DMAX  = 5,
   localparam int DEN_W = $clog2(DMAX + 1)
) (
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [Q_W-1:0]   quo
);
   localparam int SH  = NUM_W;
   localparam int M_W = SH + 1;

   logic [M_W-1:0]   recip [DMAX+1];
   logic [NUM_W-1:0] q_est;
   logic [NUM_W-1:0] rem;

   // one reciprocal constant per possible divisor, floor(2^SH / d)
   for (genvar d = 0; d <= DMAX; d++) begin : g_recip
      if (d == 0) begin : g_zero
         assign recip[d] = '0;
      end else begin : g_val
         assign recip[d] = M_W'((64'd1 << SH) / d);
      end
   end

   // estimate is either exact or one short; a single step repairs it
   assign q_est = NUM_W'((64'(num) * 64'(recip[den])) >> SH);
   assign rem   = num - NUM_W'(q_est * NUM_W'(den));
   assign quo   = Q_W'((rem >= NUM_W'(den)) ? q_est + NUM_W'(1) : q_est);
endmodule

// File: rtl/hbin_stage.sv
module hbin_stage
   import hbin_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_vld,
   input  logic             i_sol,
   input  logic [PIX_W-1:0] i_pix,
   input  hbin_scfg_t       i_cfg,
   output logic             o_vld,
   output logic             o_sol,
   output logic [PIX_W-1:0] o_pix
);
   localparam int FMAX  = 2 ** HB_FC_W;
   localparam int POS_W = $clog2(2 * FMAX);
   localparam int K_W   = POS_W - 1;
   localparam int DMAX  = FMAX + 1;
   localparam int DEN_W = $clog2(DMAX + 1);
   localparam int ACC_W = PIX_W + $clog2(FMAX + 2);
   localparam int NUM_W = ACC_W + 1;

   if (K_W != HB_FC_W) begin : g_bad_pos
      $error("hbin_stage: member index width must equal factor code width");
   end

   logic [POS_W-1:0] pos_q, pos_e;
   logic [K_W-1:0]   k;
   logic             phase;
   logic             col_done, grp_done, emit, heavy;
   logic [K_W-1:0]   fav_idx;
   logic [ACC_W-1:0] acc_q [2];
   logic [ACC_W-1:0] pix_x, base, sum_now, acc_nxt;
   logic [DEN_W-1:0] den;
   logic [NUM_W-1:0] num;
   logic [PIX_W-1:0] quo, res, resa_q, hold_q;
   logic             first_q, pend_q;

   always_comb begin
      pos_e    = i_sol ? '0 : pos_q;
      phase    = pos_e[0];
      k        = pos_e[POS_W-1:1];
      col_done = (k == i_cfg.code);
      grp_done = col_done && phase;
      emit     = i_vld && grp_done;
      fav_idx  = (phase ^ i_cfg.odd) ? i_cfg.code : '0;
      heavy    = i_cfg.fav && (k == fav_idx);
      pix_x    = heavy ? ACC_W'({i_pix, 1'b0}) : ACC_W'(i_pix);
      base     = (k == '0) ? '0 : acc_q[phase];
      sum_now  = base + pix_x;
      den      = DEN_W'(i_cfg.code) + DEN_W'(1) + DEN_W'(i_cfg.fav);
      num      = NUM_W'(sum_now) + NUM_W'(den >> 1);
   end

   hbin_rdiv #(
      .NUM_W (NUM_W),
      .Q_W   (PIX_W),
      .DMAX  (DMAX)
   ) u_rdiv (
      .num (num),
      .den (den),
      .quo (quo)
   );

   always_comb begin
      if (!i_cfg.sub) begin
         acc_nxt = sum_now;
         res     = quo;
      end else if (k == '0) begin
         acc_nxt = ACC_W'(i_pix);
         res     = i_pix;
      end else begin
         acc_nxt = acc_q[phase];
         res     = acc_q[phase][PIX_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         acc_q[0] <= '0;
         acc_q[1] <= '0;
         resa_q   <= '0;
         hold_q   <= '0;
         first_q  <= 1'b0;
         pend_q   <= 1'b0;
         o_vld    <= 1'b0;
         o_sol    <= 1'b0;
         o_pix    <= '0;
      end else begin
         if (i_vld) begin
            pos_q        <= grp_done ? '0 : pos_e + POS_W'(1);
            acc_q[phase] <= acc_nxt;
            if (col_done && !phase) resa_q <= res;
            if (grp_done)           hold_q <= res;
         end
         if (i_vld && i_sol) first_q <= 1'b1;
         else if (emit)      first_q <= 1'b0;
         if (emit) begin
            o_vld  <= 1'b1;
            o_sol  <= first_q;
            o_pix  <= resa_q;
            pend_q <= 1'b1;
         end else if (pend_q) begin
            o_vld  <= 1'b1;
            o_sol  <= 1'b0;
            o_pix  <= hold_q;
            pend_q <= 1'b0;
         end else begin
            o_vld  <= 1'b0;
            o_sol  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hbin_top.sv
module hbin_top
   import hbin_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic               in_sol,
   input  logic               in_row_odd,
   input  logic [PIX_W-1:0]   in_pix,
   input  logic [HB_FC_W-1:0] cfg_fac1,
   input  logic [HB_FC_W-1:0] cfg_fac2,
   input  logic               cfg_sub,
   input  logic               cfg_fav,
   output logic               out_vld,
   output logic               out_sol,
   output logic [PIX_W-1:0]   out_pix
);
   localparam int NSTG = 2;

   if (PIX_W < 2 || PIX_W > 24) begin : g_bad_width
      $error("hbin_top: PIX_W out of supported range");
   end

   logic             vld_w [NSTG+1];
   logic             sol_w [NSTG+1];
   logic [PIX_W-1:0] pix_w [NSTG+1];
   hbin_scfg_t       src   [NSTG];
   hbin_scfg_t       hold  [NSTG];
   hbin_scfg_t       eff   [NSTG];
   logic [HB_FC_W-1:0] fac2_q;

   assign vld_w[0] = in_vld;
   assign sol_w[0] = in_sol;
   assign pix_w[0] = in_pix;

   // stage 1 settings come straight from the ports; stage 2 follows the line
   assign src[0] = '{code: cfg_fac1, sub: cfg_sub, fav: cfg_fav, odd: in_row_odd};
   assign src[1] = '{code: fac2_q, sub: hold[0].sub, fav: hold[0].fav, odd: hold[0].odd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fac2_q <= '0;
      else if (in_vld && in_sol) fac2_q <= cfg_fac2;
   end

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      assign eff[g] = sol_w[g] ? src[g] : hold[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    hold[g] <= '0;
         else if (vld_w[g] && sol_w[g]) hold[g] <= src[g];
      end

      hbin_stage #(
         .PIX_W (PIX_W)
      ) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .i_vld (vld_w[g]),
         .i_sol (sol_w[g]),
         .i_pix (pix_w[g]),
         .i_cfg (eff[g]),
         .o_vld (vld_w[g+1]),
         .o_sol (sol_w[g+1]),
         .o_pix (pix_w[g+1])
      );
   end

   assign out_vld = vld_w[NSTG];
   assign out_sol = sol_w[NSTG];
   assign out_pix = pix_w[NSTG];
endmodule

// File: rtl/hbin_chk.sv
module hbin_chk (
   input logic clk,
   input logic rst_n,
   input logic in_vld,
   input logic in_sol,
   input logic out_vld,
   input logic out_sol
);
   logic odd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       odd_q <= 1'b0;
      else if (out_vld) odd_q <= ~odd_q;
   end

   AST_RST_IDLE: assert property (@(posedge clk)
      !rst_n |=> (!out_vld && !out_sol));                                       // R10
   AST_IN_SOL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_sol |-> in_vld);                                                       // R9
   AST_SOL_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |-> out_vld);                                                     // R8
   AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_sol) |=> (out_vld && !out_sol));                          // R3
   AST_SOL_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |-> !odd_q);                                                      // R7
endmodule

bind hbin_top hbin_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .in_sol  (in_sol),
   .out_vld (out_vld),
   .out_sol (out_sol)
);

// File: tb/hbin_top_tb.sv
module hbin_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PIX_W      = 12;
   localparam int PMAX       = (1 << PIX_W) - 1;
   localparam int WD_CYCLES  = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_vld = 1'b0, in_sol = 1'b0, in_row_odd = 1'b0;
   logic [PIX_W-1:0] in_pix = '0;
   logic [1:0]       cfg_fac1 = '0, cfg_fac2 = '0;
   logic             cfg_sub = 1'b0, cfg_fav = 1'b0;
   logic             out_vld, out_sol;
   logic [PIX_W-1:0] out_pix;

   int    vectors = 0;
   int    fails = 0;
   bit    done = 1'b0;
   int    src_q[$];
   int    dst_q[$];
   int    exp_pix[$];
   bit    exp_sol[$];
   string exp_req[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hbin_top #(.PIX_W(PIX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sol(in_sol),
      .in_row_odd(in_row_odd), .in_pix(in_pix), .cfg_fac1(cfg_fac1),
      .cfg_fac2(cfg_fac2), .cfg_sub(cfg_sub), .cfg_fav(cfg_fav),
      .out_vld(out_vld), .out_sol(out_sol), .out_pix(out_pix)
   );

   // behavioural model of one stage: src_q -> src_q
   task automatic ref_stage(input int f, input bit fav, input bit sub, input bit odd);
      int n;
      dst_q.delete();
      n = src_q.size() / (2 * f);
      for (int g = 0; g < n; g++) begin
         for (int c = 0; c < 2; c++) begin
            int v, s, d, fi;
            if (sub) begin
               v = src_q[g*2*f + c];
            end else begin
               s  = 0;
               fi = ((c ^ int'(odd)) == 0) ? 0 : f - 1;
               for (int k = 0; k < f; k++)
                  s += ((fav && k == fi) ? 2 : 1) * src_q[g*2*f + 2*k + c];
               d = f + (fav ? 1 : 0);
               v = (s + d/2) / d;
            end
            dst_q.push_back(v);
         end
      end
      src_q = dst_q;
   endtask

   function automatic int gen_pix(int pat, int seed, int i);
      if (pat == 1) return PMAX;
      if (pat == 2) return (i % 3 == 0) ? PMAX : PMAX - 1;
      return (seed * 1237 + i * 2731 + i * i * 17) % (PMAX + 1);
   endfunction

   task automatic run_line(input int len, input int f1c, input int f2c, input bit sub,
                           input bit fav, input bit odd, input int seed, input int pat,
                           input int gap, input bit scramble, input string req);
      int px[$];
      for (int i = 0; i < len; i++) px.push_back(gen_pix(pat, seed, i));
      src_q = px;
      ref_stage(f1c + 1, fav, sub, odd);
      ref_stage(f2c + 1, fav, sub, odd);
      for (int i = 0; i < src_q.size(); i++) begin
         exp_pix.push_back(src_q[i]);
         exp_sol.push_back(i == 0);
         exp_req.push_back(req);
      end
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_vld = 1'b1;
         in_sol = (i == 0);
         in_pix = PIX_W'(px[i]);
         if (i == 0 || !scramble) begin
            cfg_fac1 = 2'(f1c); cfg_fac2 = 2'(f2c);
            cfg_sub = sub; cfg_fav = fav; in_row_odd = odd;
         end else begin
            cfg_fac1 = ~2'(f1c); cfg_fac2 = ~2'(f2c);
            cfg_sub = ~sub; cfg_fav = ~fav; in_row_odd = ~odd;
         end
         for (int w = 0; w < gap; w++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_sol = 1'b0;
         end
      end
      @(negedge clk);
      in_vld = 1'b0;
      in_sol = 1'b0;
   endtask

   // compare every output beat with the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         int    ep;
         bit    es;
         string er;
         vectors++;
         if (exp_pix.size() == 0) begin
            fails++;
            $display("FAIL R7: unexpected output, actual pix=%0d sol=%0b, expected none",
                     out_pix, out_sol);
         end else begin
            ep = exp_pix.pop_front();
            es = exp_sol.pop_front();
            er = exp_req.pop_front();
            if (int'(out_pix) != ep || out_sol != es) begin
               fails++;
               $display("FAIL %s: actual pix=%0d sol=%0b, expected pix=%0d sol=%0b",
                        er, out_pix, out_sol, ep, es);
            end
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R3: watchdog expired, actual running, expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      vectors++;
      if (out_vld !== 1'b0 || out_sol !== 1'b0) begin
         fails++;
         $display("FAIL R10: in reset actual vld=%0b sol=%0b, expected 0 0", out_vld, out_sol);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      vectors++;
      if (out_vld !== 1'b0) begin
         fails++;
         $display("FAIL R10: idle after reset actual vld=%0b, expected 0", out_vld);
      end

      run_line(10, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
      run_line(16, 1, 0, 0, 0, 0, 2, 0, 0, 0, "R4");
      run_line(18, 2, 0, 0, 0, 0, 3, 2, 0, 0, "R4");
      run_line(24, 0, 3, 0, 0, 1, 4, 0, 0, 0, "R1");
      run_line(40, 2, 2, 0, 0, 0, 5, 0, 0, 0, "R1");
      run_line(64, 3, 3, 0, 0, 0, 6, 1, 0, 0, "R11");
      run_line(64, 3, 3, 0, 1, 1, 7, 1, 0, 0, "R11");
      run_line(34, 3, 1, 0, 0, 0, 8, 0, 0, 0, "R7");
      run_line(3, 1, 1, 0, 0, 0, 9, 0, 0, 0, "R7");
      run_line(16, 1, 0, 0, 1, 0, 10, 0, 0, 0, "R5");
      run_line(16, 1, 0, 0, 1, 1, 11, 0, 0, 0, "R5");
      run_line(24, 3, 0, 0, 1, 0, 12, 0, 0, 0, "R5");
      run_line(36, 2, 1, 0, 1, 1, 13, 0, 0, 0, "R5");
      run_line(36, 2, 1, 1, 0, 0, 14, 0, 0, 0, "R6");
      run_line(24, 1, 2, 1, 1, 1, 15, 0, 0, 0, "R6");
      run_line(32, 1, 1, 0, 0, 0, 16, 0, 0, 1, "R9");
      run_line(36, 2, 0, 0, 1, 0, 17, 0, 0, 1, "R9");
      run_line(24, 1, 2, 0, 0, 0, 18, 0, 2, 0, "R3");
      run_line(12, 0, 0, 0, 0, 1, 19, 0, 1, 0, "R3");
      run_line(12, 0, 0, 0, 0, 0, 20, 0, 0, 0, "R8");

      repeat (40) @(negedge clk);
      vectors++;
      if (exp_pix.size() != 0) begin
         fails++;
         $display("FAIL R8: missing outputs actual=0 expected=%0d", exp_pix.size());
      end
      done = 1'b1;
      finish_run();
   end
endmodule